// File: doc/BRIEF.md
# I2C Master SCL Timing Generator

This block produces the serial clock of an I2C master and tells the byte shifter when the data line may move. It runs from one kernel clock and takes a 32-bit timing word. The word sets a prescaler, a data-hold delay, a data-setup delay, and the counts for the SCL low and high phases. The block drives SCL low, then releases it, and repeats this for as long as `run` is held. The shifter gets two strobes. The first, `sda_chg`, marks the cycle in which the hold time after the SCL fall has elapsed. At that cycle the block also loads `sda_next` into `sda_o`. The second, `su_ok`, marks the point where the setup time before SCL may rise has passed.

The real bus levels of SCL and SDA come back through a two-stage synchronizer and a digital glitch filter, whose length can be set at run time. Every phase is timed from the moment the filtered SCL is actually seen at its new level. A slave that holds SCL low after the master has released it therefore lengthens the low time, and the following high phase keeps its full length. With `enable` low, both lines are released and all timing state returns to idle.

Top module: `i2c_scl_timing_gen`

## Requirements
- R1: The timing word fields are as follows. The prescale value P is in bits 31:28, the setup count S in bits 23:20, the hold count H in bits 19:16, the high count CH in bits 15:8 and the low count CL in bits 7:0. Bits 27:24 are ignored. One quantum lasts Q = P+1 kernel clocks.
- R2: Without stretching, `scl_o` stays low for exactly 3 + F + max((CL+1)·Q, H·Q + 1 + (S+1)·Q) clocks. F is the effective filter length.
- R3: The bus SCL stays high for exactly 3 + F + (CH+1)·Q clocks. This is counted from the cycle the line actually rises, whether the rise comes from the release or from the end of a stretch.
- R4: `sda_chg` is a one-cycle pulse 4 + F + H·Q clocks after `scl_o` falls. In that same cycle `sda_o` takes the value of `sda_next`.
- R5: `su_ok` pulses 4 + F + H·Q + (S+1)·Q clocks after `scl_o` falls. `scl_o` is never released before that pulse.
- R6: While `scl_o` is released and the bus SCL is held low, `scl_o` stays released and no new low phase starts.
- R7: `scl_seen` and `sda_seen` follow their bus lines 2 + F clocks after a change. A change that lasts fewer than F clocks does not reach them when F ≥ 1.
- R8: The effective filter length F is `dnf`. Any `dnf` value above MAX_DNF (16) is treated as 16.
- R9: With `enable` low, from the next clock `scl_o` = 1, `sda_o` = 1, and no strobe fires. Raising `enable` starts again from idle.
- R10: With `run` low, the generator completes the current high phase and then keeps `scl_o` at 1.
- R11: After reset, `scl_o` = 1, `sda_o` = 1, and `sda_chg` = `su_ok` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low releases both lines and clears all state |
| run | input | 1 | Keep generating SCL periods |
| timing | input | 32 | Timing word (fields in R1) |
| dnf | input | DNF_W (5) | Digital filter length in kernel clocks |
| scl_i | input | 1 | Sensed SCL bus level |
| sda_i | input | 1 | Sensed SDA bus level |
| sda_next | input | 1 | Next data bit from the shifter |
| scl_o | output | 1 | SCL drive: 0 pulls low, 1 releases |
| sda_o | output | 1 | SDA drive: 0 pulls low, 1 releases |
| sda_chg | output | 1 | Hold time elapsed; SDA updated this cycle |
| su_ok | output | 1 | Setup time elapsed; SCL may rise |
| scl_seen | output | 1 | Synchronized and filtered SCL |
| sda_seen | output | 1 | Synchronized and filtered SDA |

## Verification
The bench measures full SCL periods on a modelled open-drain line for three cases: one where the low count decides the low time, one where hold plus setup decides it, and one with a filter value above the limit. A design that timed phases from its own drive rather than from the sensed level, or that dropped the clamp, would be off by the synchronizer or filter latency. A stretch test holds the line low past the release. It checks that the high phase keeps its full length afterwards; a design that counted the high phase during the stretch would give a shortened high. A glitch shorter than the filter length must not reach `sda_seen`, and a long level change must arrive exactly 2 + F clocks later. Dropping `enable` or `run` in the middle of a period must leave SCL released with no stray strobe.

// File: rtl/i2c_tgen_pkg.sv
package i2c_tgen_pkg;

   localparam int TGEN_PRESC_W = 4;
   localparam int TGEN_DLY_W   = 4;
   localparam int TGEN_CNT_W   = 8;

   typedef enum logic [2:0] {
      ST_IDLE      = 3'd0,
      ST_LOW_WAIT  = 3'd1,
      ST_LOW       = 3'd2,
      ST_HIGH_WAIT = 3'd3,
      ST_HIGH      = 3'd4
   } tgen_state_e;

   typedef struct packed {
      logic [TGEN_PRESC_W-1:0] presc;
      logic [3:0]              spare;
      logic [TGEN_DLY_W-1:0]   setup;
      logic [TGEN_DLY_W-1:0]   hold;
      logic [TGEN_CNT_W-1:0]   high;
      logic [TGEN_CNT_W-1:0]   low;
   } tgen_timing_t;

endpackage

// File: rtl/tgen_line_filter.sv
module tgen_line_filter #(
   parameter int MAX_DNF     = 16,
   parameter bit FILTER_EN   = 1'b1,
   parameter int SYNC_STAGES = 2,
   parameter int DNF_W       = $clog2(MAX_DNF + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DNF_W-1:0] dnf,
   input  logic             line_i,
   output logic             seen_o
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("tgen_line_filter: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   sync_out;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   sync_q <= '1;
      else if (!en) sync_q <= '1;
      else          sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
   end

   assign sync_out = sync_q[SYNC_STAGES-1];

   if (FILTER_EN) begin : g_filter
      logic [DNF_W-1:0] dnf_eff;
      logic [DNF_W-1:0] cnt_q;
      logic             filt_q;

      assign dnf_eff = (dnf > DNF_W'(MAX_DNF)) ? DNF_W'(MAX_DNF) : dnf;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            filt_q <= 1'b1;
            cnt_q  <= '0;
         end else if (!en) begin
            filt_q <= 1'b1;
            cnt_q  <= '0;
         end else if (dnf_eff == '0) begin
            filt_q <= sync_out;
            cnt_q  <= '0;
         end else if (sync_out == filt_q) begin
            cnt_q  <= '0;
         end else if (cnt_q == dnf_eff - DNF_W'(1)) begin
            filt_q <= sync_out;
            cnt_q  <= '0;
         end else begin
            cnt_q  <= cnt_q + DNF_W'(1);
         end
      end

      assign seen_o = (dnf_eff == '0) ? sync_out : filt_q;

      AST_FILTER_TAKES_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(en) && filt_q != $past(filt_q)) |-> (filt_q == $past(sync_out))); // R7
   end else begin : g_bypass
      logic unused_dnf;
      assign unused_dnf = ^dnf;
      assign seen_o     = sync_out;
   end

endmodule

// File: rtl/tgen_quanta_timer.sv
module tgen_quanta_timer #(
   parameter int PRESC_W = 4,
   parameter int CNT_W   = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic               run,
   input  logic [PRESC_W-1:0] presc,
   input  logic [CNT_W-1:0]   limit,
   output logic [PRESC_W-1:0] pcnt_o,
   output logic [CNT_W-1:0]   qcnt_o,
   output logic               hit_o
);

   if (PRESC_W < 1 || CNT_W < 1) begin : g_bad_width
      $error("tgen_quanta_timer: widths must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pcnt_o <= '0;
         qcnt_o <= '0;
      end else if (clear) begin
         pcnt_o <= '0;
         qcnt_o <= '0;
      end else if (run) begin
         if (pcnt_o == presc) begin
            pcnt_o <= '0;
            qcnt_o <= qcnt_o + CNT_W'(1);
         end else begin
            pcnt_o <= pcnt_o + PRESC_W'(1);
         end
      end
   end

   assign hit_o = run && (pcnt_o == presc) && (qcnt_o == limit);

endmodule

// File: rtl/tgen_phase_ctrl.sv
module tgen_phase_ctrl
   import i2c_tgen_pkg::*;
#(
   parameter int PRESC_W = TGEN_PRESC_W,
   parameter int DLY_W   = TGEN_DLY_W,
   parameter int CNT_W   = TGEN_CNT_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               run,
   input  logic [DLY_W-1:0]   hold_dly,
   input  logic [CNT_W-1:0]   low_cnt,
   input  logic [CNT_W-1:0]   high_cnt,
   input  logic               scl_seen,
   input  logic               sda_next,
   input  logic [PRESC_W-1:0] ph_pcnt,
   input  logic [CNT_W-1:0]   ph_qcnt,
   input  logic               ph_hit,
   input  logic               su_hit,
   output logic               ph_clear,
   output logic               ph_run,
   output logic [CNT_W-1:0]   ph_limit,
   output logic               su_clear,
   output logic               su_run,
   output logic               scl_o,
   output logic               sda_o,
   output logic               sda_chg,
   output logic               su_ok
);

   tgen_state_e state_q, state_n;
   logic lo_done_q, su_done_q, hold_done_q, su_active_q;
   logic hold_fire, su_fire, lo_ok, su_met;

   assign hold_fire = (state_q == ST_LOW) && !hold_done_q &&
                      (ph_pcnt == '0) && (ph_qcnt == CNT_W'(hold_dly));
   assign su_fire   = su_active_q && su_hit && !su_done_q;
   assign lo_ok     = lo_done_q || ((state_q == ST_LOW) && ph_hit);
   assign su_met    = su_done_q || su_fire;

   always_comb begin
      state_n = state_q;
      unique case (state_q)
         ST_IDLE:      if (run)             state_n = ST_LOW_WAIT;
         ST_LOW_WAIT:  if (!scl_seen)       state_n = ST_LOW;
         ST_LOW:       if (lo_ok && su_met) state_n = ST_HIGH_WAIT;
         ST_HIGH_WAIT: if (scl_seen)        state_n = ST_HIGH;
         ST_HIGH:      if (ph_hit)          state_n = run ? ST_LOW_WAIT : ST_IDLE;
         default:                           state_n = ST_IDLE;
      endcase
   end

   assign ph_run   = (state_q == ST_LOW) || (state_q == ST_HIGH);
   assign ph_clear = !en || (state_n != state_q);
   assign ph_limit = (state_q == ST_HIGH) ? high_cnt : low_cnt;
   assign su_run   = su_active_q;
   assign su_clear = !en || hold_fire || (state_q != ST_LOW);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         scl_o       <= 1'b1;
         sda_o       <= 1'b1;
         sda_chg     <= 1'b0;
         su_ok       <= 1'b0;
         lo_done_q   <= 1'b0;
         su_done_q   <= 1'b0;
         hold_done_q <= 1'b0;
         su_active_q <= 1'b0;
      end else if (!en) begin
         state_q     <= ST_IDLE;
         scl_o       <= 1'b1;
         sda_o       <= 1'b1;
         sda_chg     <= 1'b0;
         su_ok       <= 1'b0;
         lo_done_q   <= 1'b0;
         su_done_q   <= 1'b0;
         hold_done_q <= 1'b0;
         su_active_q <= 1'b0;
      end else begin
         state_q <= state_n;
         scl_o   <= !((state_n == ST_LOW_WAIT) || (state_n == ST_LOW));
         sda_chg <= hold_fire;
         su_ok   <= su_fire;
         if (hold_fire) sda_o <= sda_next;
         if (state_n != ST_LOW) begin
            lo_done_q   <= 1'b0;
            su_done_q   <= 1'b0;
            hold_done_q <= 1'b0;
            su_active_q <= 1'b0;
         end else begin
            if ((state_q == ST_LOW) && ph_hit) lo_done_q <= 1'b1;
            if (su_fire)   su_done_q   <= 1'b1;
            if (hold_fire) hold_done_q <= 1'b1;
            if (hold_fire) su_active_q <= 1'b1;
         end
      end
   end

   AST_OFF_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (scl_o && sda_o && !sda_chg && !su_ok)); // R9
   AST_CHG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (en && sda_chg) |=> !sda_chg); // R4
   AST_STRETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (en && state_q == ST_HIGH_WAIT && !scl_seen) |=> scl_o); // R6
   AST_FALL_AFTER_HIGH_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(scl_o) && $past(en) && $past(state_q) != ST_IDLE) |-> $past(scl_seen)); // R3
   AST_RELEASE_NEEDS_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(scl_o) && $past(en) && $past(state_q) == ST_LOW) |-> (su_ok || $past(su_done_q))); // R5

endmodule

// File: rtl/i2c_scl_timing_gen.sv
module i2c_scl_timing_gen
   import i2c_tgen_pkg::*;
#(
   parameter int MAX_DNF     = 16,
   parameter bit FILTER_EN   = 1'b1,
   parameter int SYNC_STAGES = 2,
   parameter int DNF_W       = $clog2(MAX_DNF + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             run,
   input  logic [31:0]      timing,
   input  logic [DNF_W-1:0] dnf,
   input  logic             scl_i,
   input  logic             sda_i,
   input  logic             sda_next,
   output logic             scl_o,
   output logic             sda_o,
   output logic             sda_chg,
   output logic             su_ok,
   output logic             scl_seen,
   output logic             sda_seen
);

   localparam int NUM_LINES = 2;

   if (MAX_DNF < 1 || MAX_DNF > 255) begin : g_bad_dnf
      $error("i2c_scl_timing_gen: MAX_DNF out of range");
   end
   if ($bits(tgen_timing_t) != 32) begin : g_bad_word
      $error("i2c_scl_timing_gen: timing word layout must be 32 bits");
   end

   tgen_timing_t tw;
   assign tw = tgen_timing_t'(timing);

   logic unused_spare;
   assign unused_spare = ^tw.spare;

   logic [NUM_LINES-1:0] line_in, line_seen;
   assign line_in  = {sda_i, scl_i};
   assign scl_seen = line_seen[0];
   assign sda_seen = line_seen[1];

   for (genvar li = 0; li < NUM_LINES; li++) begin : g_line
      tgen_line_filter #(
         .MAX_DNF    (MAX_DNF),
         .FILTER_EN  (FILTER_EN),
         .SYNC_STAGES(SYNC_STAGES),
         .DNF_W      (DNF_W)
      ) u_filt (
         .clk   (clk),
         .rst_n (rst_n),
         .en    (enable),
         .dnf   (dnf),
         .line_i(line_in[li]),
         .seen_o(line_seen[li])
      );
   end

   logic                    ph_clear, ph_run, ph_hit;
   logic [TGEN_CNT_W-1:0]   ph_limit, ph_qcnt;
   logic [TGEN_PRESC_W-1:0] ph_pcnt;
   logic                    su_clear, su_run, su_hit;
   logic [TGEN_PRESC_W-1:0] unused_su_pcnt;
   logic [TGEN_CNT_W-1:0]   unused_su_qcnt;

   tgen_quanta_timer #(.PRESC_W(TGEN_PRESC_W), .CNT_W(TGEN_CNT_W)) u_phase_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (ph_clear),
      .run   (ph_run),
      .presc (tw.presc),
      .limit (ph_limit),
      .pcnt_o(ph_pcnt),
      .qcnt_o(ph_qcnt),
      .hit_o (ph_hit)
   );

   tgen_quanta_timer #(.PRESC_W(TGEN_PRESC_W), .CNT_W(TGEN_CNT_W)) u_setup_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (su_clear),
      .run   (su_run),
      .presc (tw.presc),
      .limit (TGEN_CNT_W'(tw.setup)),
      .pcnt_o(unused_su_pcnt),
      .qcnt_o(unused_su_qcnt),
      .hit_o (su_hit)
   );

   tgen_phase_ctrl #(
      .PRESC_W(TGEN_PRESC_W),
      .DLY_W  (TGEN_DLY_W),
      .CNT_W  (TGEN_CNT_W)
   ) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (enable),
      .run     (run),
      .hold_dly(tw.hold),
      .low_cnt (tw.low),
      .high_cnt(tw.high),
      .scl_seen(scl_seen),
      .sda_next(sda_next),
      .ph_pcnt (ph_pcnt),
      .ph_qcnt (ph_qcnt),
      .ph_hit  (ph_hit),
      .su_hit  (su_hit),
      .ph_clear(ph_clear),
      .ph_run  (ph_run),
      .ph_limit(ph_limit),
      .su_clear(su_clear),
      .su_run  (su_run),
      .scl_o   (scl_o),
      .sda_o   (sda_o),
      .sda_chg (sda_chg),
      .su_ok   (su_ok)
   );

endmodule

// File: tb/i2c_scl_timing_gen_tb_top.sv
module i2c_scl_timing_gen_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int MAXF       = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enable = 1'b0, run = 1'b0;
   logic [31:0] timing = '0;
   logic [4:0]  dnf = '0;
   logic sda_drv = 1'b1, sda_next = 1'b1, stretch = 1'b0;
   logic scl_o, sda_o, sda_chg, su_ok, scl_seen, sda_seen;
   logic scl_line;

   int checks = 0;
   int fails  = 0;

   assign scl_line = scl_o & ~stretch;

   always #(CLK_PERIOD/2) clk = ~clk;

   i2c_scl_timing_gen dut_i (
      .clk(clk), .rst_n(rst_n), .enable(enable), .run(run), .timing(timing),
      .dnf(dnf), .scl_i(scl_line), .sda_i(sda_drv), .sda_next(sda_next),
      .scl_o(scl_o), .sda_o(sda_o), .sda_chg(sda_chg), .su_ok(su_ok),
      .scl_seen(scl_seen), .sda_seen(sda_seen)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp_v);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
      end
   endtask

   function automatic int eff_f(input int d);
      return (d > MAXF) ? MAXF : d;
   endfunction

   task automatic set_cfg(input int p, input int s, input int h, input int ch,
                          input int cl, input int d, input bit go);
      @(posedge clk); #1;
      enable = 1'b0; run = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      timing = {4'(p), 4'h0, 4'(s), 4'(h), 8'(ch), 8'(cl)};
      dnf    = 5'(d);
      enable = 1'b1;
      run    = go;
   endtask

   task automatic measure(output int lo, output int hi, output int chg,
                          output int su, output int nchg, output logic sda_after);
      int guard = 0;
      int idx   = 0;
      lo = 0; hi = 0; chg = -1; su = -1; nchg = 0;
      do begin @(negedge clk); guard++; end while (scl_line !== 1'b1 && guard < 5000);
      do begin @(negedge clk); guard++; end while (scl_line !== 1'b0 && guard < 5000);
      while (scl_line == 1'b0 && guard < 5000) begin
         if (sda_chg) begin nchg++; if (chg < 0) chg = idx; end
         if (su_ok && su < 0) su = idx;
         idx++; guard++;
         @(negedge clk);
      end
      if (su_ok && su < 0) su = idx;
      lo = idx;
      sda_after = sda_o;
      while (scl_line == 1'b1 && guard < 5000) begin
         hi++; guard++;
         @(negedge clk);
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(scl_o == 1'b1, "R11 scl_o", scl_o, 1);
      chk(sda_o == 1'b1, "R11 sda_o", sda_o, 1);
      chk(sda_chg == 1'b0, "R11 sda_chg", sda_chg, 0);
      chk(su_ok == 1'b0, "R11 su_ok", su_ok, 0);
   endtask

   task automatic t_period(input int p, input int s, input int h, input int ch,
                           input int cl, input int d);
      int lo, hi, chg, su, nchg, q, f, a, b;
      logic sda_after;
      q = p + 1; f = eff_f(d);
      a = (cl + 1) * q;
      b = h * q + 1 + (s + 1) * q;
      sda_next = 1'b0;
      set_cfg(p, s, h, ch, cl, d, 1'b1);
      measure(lo, hi, chg, su, nchg, sda_after);
      chk(lo == 3 + f + ((a > b) ? a : b), "R2/R1/R8 low length", lo, 3 + f + ((a > b) ? a : b));
      chk(hi == 3 + f + (ch + 1) * q, "R3 high length", hi, 3 + f + (ch + 1) * q);
      chk(chg == 4 + f + h * q, "R4 hold strobe offset", chg, 4 + f + h * q);
      chk(nchg == 1, "R4 hold strobe width", nchg, 1);
      chk(sda_after == 1'b0, "R4 sda_o loaded", sda_after, 0);
      chk(su == 4 + f + h * q + (s + 1) * q, "R5 setup strobe offset", su, 4 + f + h * q + (s + 1) * q);
      chk(su <= lo, "R5 release not before setup", su, lo);
   endtask

   task automatic t_stretch();
      int lowc = 0;
      int hi   = 0;
      int guard = 0;
      set_cfg(0, 1, 0, 3, 4, 0, 1'b1);
      do begin @(negedge clk); guard++; end while (scl_line !== 1'b0 && guard < 5000);
      stretch = 1'b1;
      repeat (30) begin
         @(negedge clk);
         if (scl_line == 1'b0) lowc++;
      end
      chk(scl_o == 1'b1, "R6 released during stretch", scl_o, 1);
      chk(lowc == 30, "R6 line held low", lowc, 30);
      @(posedge clk); #1;
      stretch = 1'b0;
      @(negedge clk);
      while (scl_line == 1'b1 && guard < 5000) begin
         hi++; guard++;
         @(negedge clk);
      end
      chk(hi == 3 + 4, "R3 high after stretch", hi, 7);
   endtask

   task automatic t_filter(input int d, input bit do_glitch);
      int j = 0;
      int bad = 0;
      set_cfg(0, 0, 0, 3, 3, d, 1'b0);
      repeat (6) @(posedge clk);
      if (do_glitch) begin
         #1 sda_drv = 1'b0;
         repeat (3) @(posedge clk);
         #1 sda_drv = 1'b1;
         repeat (20) begin
            @(negedge clk);
            if (sda_seen != 1'b1) bad++;
         end
         chk(bad == 0, "R7 short glitch rejected", bad, 0);
         @(posedge clk);
      end
      #1 sda_drv = 1'b0;
      @(negedge clk);
      while (sda_seen == 1'b1 && j < 100) begin
         j++;
         @(negedge clk);
      end
      chk(j == 2 + eff_f(d), "R7 filtered latency", j, 2 + eff_f(d));
      @(posedge clk); #1 sda_drv = 1'b1;
      repeat (30) @(posedge clk);
   endtask

   task automatic t_enable();
      int bad = 0;
      int guard = 0;
      int lo, hi, chg, su, nchg;
      logic sda_after;
      set_cfg(0, 1, 0, 3, 4, 0, 1'b1);
      do begin @(negedge clk); guard++; end while (scl_line !== 1'b0 && guard < 5000);
      repeat (3) @(negedge clk);
      @(posedge clk); #1 enable = 1'b0;
      repeat (2) @(negedge clk);
      chk(scl_o == 1'b1, "R9 scl released", scl_o, 1);
      chk(sda_o == 1'b1, "R9 sda released", sda_o, 1);
      repeat (20) begin
         @(negedge clk);
         if (sda_chg || su_ok || !scl_o) bad++;
      end
      chk(bad == 0, "R9 quiet while disabled", bad, 0);
      @(posedge clk); #1 enable = 1'b1;
      measure(lo, hi, chg, su, nchg, sda_after);
      chk(lo == 8, "R9 restart low length", lo, 8);
   endtask

   task automatic t_run_stop();
      int lows = 0;
      set_cfg(0, 1, 0, 3, 4, 0, 1'b1);
      repeat (30) @(posedge clk);
      #1 run = 1'b0;
      repeat (40) @(negedge clk);
      repeat (40) begin
         @(negedge clk);
         if (scl_o == 1'b0) lows++;
      end
      chk(lows == 0, "R10 idle after run drops", lows, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      t_reset();
      @(posedge clk); #1 rst_n = 1'b1;
      t_reset();
      t_period(0, 1, 0, 3, 4, 0);
      t_period(2, 3, 2, 2, 1, 2);
      t_period(1, 0, 1, 5, 7, 31);
      t_stretch();
      t_filter(4, 1'b1);
      t_filter(0, 1'b0);
      t_enable();
      t_run_stop();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule